// File: doc/BRIEF.md
# ADC Conversion and Readback Sequencer

This block runs on the host side of a serial analog-to-digital converter that flags the end of each conversion on its own data line. It drives the convert-strobe line and the serial clock toward the converter. It shifts a configuration word out on the serial input line and captures the serial data line. One start request runs a complete cycle. The block issues a short convert pulse, then waits for the data line to drop low, which marks completion. It then gives a second short pulse that moves the converter out of its idle state and back into acquisition. Finally it clocks a frame of either 12 bits (the result only) or 28 bits (the result followed by the 16-bit configuration word).

When the frame ends, the block presents the 12-bit result. For a 28-bit frame it also presents the channel field taken from the returned configuration word. Both come with a single-cycle done strobe. The block keeps a minimum acquisition time between the strobe that leaves idle and the next conversion strobe. If completion never appears, a watchdog on the conversion wait flags an error. The serial clock half-period, the strobe width, the minimum acquisition time and the maximum conversion wait are all counted in system clocks.

Top module: `adc_eoc_sequencer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cnv_o`, `sclk_o`, `sdi_o`, `busy_o`, `done_o` and `err_o` are low, and `result_o` and `channel_o` are zero.
- R2: A start request that is accepted at a clock edge drives `cnv_o` high for exactly CNV_HI cycles, starting in the following cycle. `busy_o` is high from that cycle on.
- R3: After the convert pulse, `cnv_o` and `sclk_o` stay low until completion. `sdo_i` is registered once. The exit pulse begins on the second clock edge after the first edge at which `sdo_i` is low during the wait.
- R4: The exit pulse holds `cnv_o` high for exactly CNV_HI cycles. Serial clocking starts in the cycle after `cnv_o` falls.
- R5: Each serial bit lasts 2*SCLK_HALF cycles: `sclk_o` is low for SCLK_HALF cycles, then high for SCLK_HALF cycles. `sdo_i` is sampled at the edge where `sclk_o` rises. A frame has 12 bits, or 28 bits if `readback_i` was high when the request was accepted. `sclk_o` is never high together with `cnv_o`.
- R6: The first captured bit is the MSB of the result. In a 28-bit frame, the first 12 bits are the result (MSB first) and the next 16 bits are the configuration word (MSB first).
- R7: After a 28-bit frame, `channel_o` equals bits [CH_LSB+CH_W-1:CH_LSB] of the returned configuration word (bits 12..10 by default). A 12-bit frame leaves `channel_o` unchanged.
- R8: `done_o` is high for exactly one cycle, the cycle after the last high phase of `sclk_o`. In that cycle `result_o` holds the new result and `busy_o` is low.
- R9: `sdi_o` carries `cfg_word_i`, captured when the request is accepted, MSB first, one bit per serial period. Each bit is valid from the start of its low phase. Bits beyond the 16th, and all idle time, are 0.
- R10: A conversion strobe starts no earlier than ACQ_MIN+1 cycles after `cnv_o` falls at the end of the exit pulse, and no earlier than ACQ_MIN+1 cycles after reset or a timeout. A request that arrives earlier is held and is served on the first edge at which this is met.
- R11: If `sdo_i` has not been seen low by the last of MAX_CONV wait cycles, `err_o` pulses for one cycle. The block then returns to idle with `busy_o` low, gives no done strobe, and leaves `result_o` and `channel_o` unchanged.
- R12: `start_i` is ignored while `busy_o` is high; it is not held as a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion-and-readback cycle |
| readback_i | input | 1 | Select the 28-bit frame with configuration readback (captured on acceptance) |
| cfg_word_i | input | CFG_W | Configuration word sent on the serial input line (captured on acceptance) |
| sdo_i | input | 1 | Converter serial data line, also the end-of-conversion flag |
| cnv_o | output | 1 | Convert strobe toward the converter |
| sclk_o | output | 1 | Serial clock toward the converter |
| sdi_o | output | 1 | Serial configuration data toward the converter |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-cycle strobe: result and channel are valid |
| err_o | output | 1 | One-cycle strobe: conversion wait timed out |
| result_o | output | DATA_W | Last conversion result |
| channel_o | output | CH_W | Channel field from the last readback frame |

## Verification
Frames are run with different completion delays, from zero through the last cycle before the timeout limit. These runs separate a correct completion latency from an early or late exit strobe. Data and configuration patterns are chosen to be asymmetric, so a reversed bit order or a slipped frame alignment shows up. Plain and readback frames are mixed back to back to separate the two frame lengths and show that the channel field is kept across plain frames. A start issued right after a short frame, a start issued during the wait, and a completion that never arrives exercise, respectively, the held request under the acquisition limit, the dropped request while busy, and the error path with its unchanged outputs.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CONV,
    S_WAIT,
    S_EXIT,
    S_SHIFT
  } seq_state_e;
endpackage

// File: rtl/adcseq_acq_guard.sv
// Saturating count of cycles since acquisition began.
module adcseq_acq_guard #(
  parameter int ACQ_MIN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic ok
);
  localparam int AW = $clog2(ACQ_MIN + 1) + 1;
  localparam logic [AW-1:0] LIMIT = AW'(ACQ_MIN);

  logic [AW-1:0] acq_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acq_cnt <= '0;
    end else if (acq_cnt != LIMIT) begin
      acq_cnt <= acq_cnt + 1'b1;
    end
  end

  assign ok = (acq_cnt == LIMIT);
endmodule

// File: rtl/adcseq_sclk_gen.sv
// Serial clock phase and bit counting for one frame.
module adcseq_sclk_gen #(
  parameter int HALF = 2,
  parameter int MAXB = 28
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run,
  input  logic [$clog2(MAXB+1)-1:0]  nbits,
  output logic                       sclk_o,
  output logic                       sample_o,
  output logic                       bit_end_o,
  output logic                       last_o
);
  localparam int PH_W = (2 * HALF > 2) ? $clog2(2 * HALF) : 1;
  localparam int B_W  = $clog2(MAXB + 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] PH_END  = PH_W'(2 * HALF - 1);
  localparam logic [PH_W-1:0] PH_HI   = PH_W'(HALF);

  logic [PH_W-1:0] ph;
  logic [B_W-1:0]  bidx;
  logic            sclk_q;

  assign sample_o  = run && (ph == PH_RISE);
  assign bit_end_o = run && (ph == PH_END);
  assign last_o    = bit_end_o && (bidx == nbits - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run || last_o) begin
      ph     <= '0;
      bidx   <= '0;
      sclk_q <= 1'b0;
    end else if (bit_end_o) begin
      ph     <= '0;
      bidx   <= bidx + 1'b1;
      sclk_q <= 1'b0;
    end else begin
      ph     <= ph + 1'b1;
      sclk_q <= ((ph + 1'b1) >= PH_HI);
    end
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/adcseq_shifter.sv
// Configuration word out on the serial input line, frame capture from the data line.
module adcseq_shifter #(
  parameter int CFG_W = 16,
  parameter int RX_W  = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             adv,
  input  logic             hold,
  input  logic             sample,
  input  logic             sdo_i,
  output logic             sdi_o,
  output logic [RX_W-1:0]  rx_o
);
  logic [CFG_W-1:0] tx;
  logic             sdi_q;
  logic [RX_W-1:0]  rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx    <= '0;
      sdi_q <= 1'b0;
    end else if (load) begin
      tx    <= cfg_i;
      sdi_q <= 1'b0;
    end else if (adv) begin
      sdi_q <= tx[CFG_W-1];
      tx    <= {tx[CFG_W-2:0], 1'b0};
    end else if (!hold) begin
      sdi_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      rx <= '0;
    end else if (sample) begin
      rx <= {rx[RX_W-2:0], sdo_i};
    end
  end

  assign sdi_o = sdi_q;
  assign rx_o  = rx;
endmodule

// File: rtl/adc_eoc_sequencer.sv
module adc_eoc_sequencer
  import adcseq_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int CFG_W     = 16,
  parameter int CH_LSB    = 10,
  parameter int CH_W      = 3,
  parameter int SCLK_HALF = 2,
  parameter int CNV_HI    = 3,
  parameter int ACQ_MIN   = 64,
  parameter int MAX_CONV  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              readback_i,
  input  logic [CFG_W-1:0]  cfg_word_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] result_o,
  output logic [CH_W-1:0]   channel_o
);
  localparam int FRAME_RB = DATA_W + CFG_W;
  localparam int B_W      = $clog2(FRAME_RB + 1);
  localparam int CNT_MAX  = (MAX_CONV > CNV_HI) ? MAX_CONV : CNV_HI;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNV_LAST = CNT_W'(CNV_HI - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(MAX_CONV - 1);

  seq_state_e st, st_n;
  logic [CNT_W-1:0]  cnt;
  logic              sdo_q, pend, rb_q;
  logic              cnv_q, busy_q, done_q, err_q;
  logic [DATA_W-1:0] result_q;
  logic [CH_W-1:0]   chan_q;

  logic acq_ok, accept, cnv_end, tmo, enter_shift;
  logic sample, bit_end, last;
  logic [B_W-1:0]      nbits;
  logic [FRAME_RB-1:0] rx;

  assign accept      = (st == S_IDLE) && (start_i || pend) && acq_ok;
  assign cnv_end     = (cnt == CNV_LAST);
  assign tmo         = (st == S_WAIT) && sdo_q && (cnt == TMO_LAST);
  assign enter_shift = (st == S_EXIT) && cnv_end;
  assign nbits       = rb_q ? B_W'(FRAME_RB) : B_W'(DATA_W);

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:  if (accept)   st_n = S_CONV;
      S_CONV:  if (cnv_end)  st_n = S_WAIT;
      S_WAIT:  if (!sdo_q)   st_n = S_EXIT;
               else if (tmo) st_n = S_IDLE;
      S_EXIT:  if (cnv_end)  st_n = S_SHIFT;
      S_SHIFT: if (last)     st_n = S_IDLE;
      default:               st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sdo_q  <= 1'b1;
      pend   <= 1'b0;
      rb_q   <= 1'b0;
      cnv_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st     <= st_n;
      sdo_q  <= sdo_i;
      cnt    <= (st_n != st || st == S_IDLE || st == S_SHIFT) ? '0 : cnt + 1'b1;
      cnv_q  <= (st_n == S_CONV) || (st_n == S_EXIT);
      busy_q <= (st_n != S_IDLE);
      done_q <= (st == S_SHIFT) && last;
      err_q  <= tmo;
      if (accept) begin
        pend <= 1'b0;
        rb_q <= readback_i;
      end else if (st == S_IDLE && start_i) begin
        pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      chan_q   <= '0;
    end else if (st == S_SHIFT && last) begin
      if (rb_q) begin
        result_q <= rx[FRAME_RB-1 -: DATA_W];
        chan_q   <= rx[CH_LSB +: CH_W];
      end else begin
        result_q <= rx[DATA_W-1:0];
      end
    end
  end

  adcseq_acq_guard #(.ACQ_MIN(ACQ_MIN)) u_acq (
    .clk (clk),
    .rst (rst),
    .clr (enter_shift || tmo),
    .ok  (acq_ok)
  );

  adcseq_sclk_gen #(.HALF(SCLK_HALF), .MAXB(FRAME_RB)) u_sclk (
    .clk       (clk),
    .rst       (rst),
    .run       (st == S_SHIFT),
    .nbits     (nbits),
    .sclk_o    (sclk_o),
    .sample_o  (sample),
    .bit_end_o (bit_end),
    .last_o    (last)
  );

  adcseq_shifter #(.CFG_W(CFG_W), .RX_W(FRAME_RB)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .cfg_i  (cfg_word_i),
    .adv    (enter_shift || (bit_end && !last)),
    .hold   ((st == S_SHIFT) && !last),
    .sample (sample),
    .sdo_i  (sdo_i),
    .sdi_o  (sdi_o),
    .rx_o   (rx)
  );

  assign cnv_o     = cnv_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign result_o  = result_q;
  assign channel_o = chan_q;
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
  parameter int CNV_HI  = 3,
  parameter int ACQ_MIN = 64
) (
  input logic clk,
  input logic rst,
  input logic cnv_o,
  input logic sclk_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  localparam int HW = $clog2(CNV_HI + 2);
  localparam int LW = $clog2(ACQ_MIN + 2);
  localparam logic [HW-1:0] HI_SAT = HW'(CNV_HI + 1);
  localparam logic [LW-1:0] LO_SAT = LW'(ACQ_MIN + 1);

  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= !cnv_o ? '0 : (hi_cnt == HI_SAT) ? hi_cnt : hi_cnt + 1'b1;
      lo_cnt <= cnv_o ? '0 : (lo_cnt == LO_SAT) ? lo_cnt : lo_cnt + 1'b1;
    end
  end

  // R2, R4: every strobe is exactly CNV_HI cycles wide
  p_strobe_width_r2: assert property (@(posedge clk) disable iff (rst)
    (!cnv_o && hi_cnt != '0) |-> (hi_cnt == HW'(CNV_HI)));

  // R10: a conversion strobe from idle follows enough low cycles
  p_acq_window_r10: assert property (@(posedge clk) disable iff (rst)
    ($rose(cnv_o) && !$past(busy_o)) |-> ($past(lo_cnt) >= LW'(ACQ_MIN)));

  // R5: serial clock only inside a busy cycle and never with the strobe
  p_sclk_apart_r5: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> (busy_o && !cnv_o));

  // R8: single-cycle done strobe, outside the busy window
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !sclk_o && !cnv_o));

  // R11: timeout flag is a single-cycle pulse in idle with no done
  p_err_single_r11: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
  p_err_idle_r11: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!busy_o && !cnv_o && !done_o));
endmodule

bind adc_eoc_sequencer adcseq_checker #(.CNV_HI(CNV_HI), .ACQ_MIN(ACQ_MIN)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cnv_o  (cnv_o),
  .sclk_o (sclk_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .err_o  (err_o)
);

// File: tb/sim_adc_eoc_sequencer.sv
`timescale 1ns/1ps
module sim_adc_eoc_sequencer;
  localparam int H   = 2;
  localparam int CH  = 3;
  localparam int ACQ = 64;
  localparam int MXC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic readback_i = 1'b0;
  logic [15:0] cfg_word_i = '0;
  logic sdo_i = 1'b1;
  logic cnv_o, sclk_o, sdi_o, busy_o, done_o, err_o;
  logic [11:0] result_o;
  logic [2:0]  channel_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0]  exp_ch  = '0;
  logic [11:0] exp_res = '0;

  always #2.5 clk = ~clk;

  adc_eoc_sequencer #(
    .DATA_W(12), .CFG_W(16), .CH_LSB(10), .CH_W(3),
    .SCLK_HALF(H), .CNV_HI(CH), .ACQ_MIN(ACQ), .MAX_CONV(MXC)
  ) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .readback_i(readback_i),
    .cfg_word_i(cfg_word_i), .sdo_i(sdo_i), .cnv_o(cnv_o), .sclk_o(sclk_o),
    .sdi_o(sdi_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .result_o(result_o), .channel_o(channel_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock of the reference timeline: {cnv, sclk, busy, done, err}
  task automatic step(input logic [4:0] exp, input string tag);
    @(negedge clk);
    check(tag, {27'd0, cnv_o, sclk_o, busy_o, done_o, err_o}, {27'd0, exp});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(5'b00000, tag);
  endtask

  task automatic run_frame(input bit rb, input logic [15:0] cfg, input logic [11:0] dat,
                           input logic [15:0] rcfg, input int ct, input int pre, input bit poke);
    int nb;
    logic [27:0] fr;
    nb = rb ? 28 : 12;
    fr = rb ? {dat, rcfg} : {dat, 16'h0000};
    start_i = 1'b1;
    readback_i = rb;
    cfg_word_i = cfg;
    for (int i = 0; i < pre; i++) begin
      step(5'b00000, "R10 request held for acquisition");
      start_i = 1'b0;
    end
    for (int i = 0; i < CH; i++) begin
      step(5'b10100, "R2 convert strobe");
      start_i = 1'b0;
    end
    for (int j = 0; j <= ct + 1; j++) begin
      step(5'b00100, "R3 waiting for completion");
      if (j == ct) sdo_i = 1'b0;
      if (poke) start_i = (j == 0);
    end
    start_i = 1'b0;
    for (int k = 0; k < CH; k++) begin
      step(5'b10100, "R4 exit strobe");
      sdo_i = 1'b1;
    end
    for (int b = 0; b < nb; b++) begin
      for (int c = 0; c < 2 * H; c++) begin
        step({1'b0, (c >= H), 1'b1, 2'b00}, "R5 serial clock");
        if (c == 0) sdo_i = fr[27-b];
        if (c == H) check("R9 sdi bit", {31'd0, sdi_o}, {31'd0, (b < 16) ? cfg[15-b] : 1'b0});
      end
    end
    step(5'b00010, "R8 done strobe");
    sdo_i = 1'b1;
    exp_res = dat;
    if (rb) exp_ch = rcfg[12:10];
    check("R6 result", {20'd0, result_o}, {20'd0, exp_res});
    check("R7 channel", {29'd0, channel_o}, {29'd0, exp_ch});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 outputs in reset", {7'd0, cnv_o, sclk_o, sdi_o, busy_o, done_o, err_o, result_o, channel_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 outputs after reset", {7'd0, cnv_o, sclk_o, sdi_o, busy_o, done_o, err_o, result_o, channel_o}, 32'd0);
    idle(70, "R10 idle after reset");

    // plain frame, moderate completion delay
    run_frame(1'b0, 16'hB3F1, 12'hA5C, 16'h0000, 5, 0, 1'b0);
    idle(70, "R10 idle");
    // readback frame, immediate completion
    run_frame(1'b1, 16'h8E01, 12'h3C7, 16'h1423, 0, 0, 1'b0);
    // long frame covers acquisition: plain frame at once, completion at the last legal cycle
    run_frame(1'b0, 16'h0000, 12'hFFF, 16'h0000, MXC - 2, 0, 1'b0);
    // short frame: request right away is held for ACQ - 48 cycles (R10)
    run_frame(1'b0, 16'h6A96, 12'h001, 16'h0000, 12, ACQ - 12 * 2 * H, 1'b0);
    idle(70, "R10 idle");
    // R12: start pulsed during the wait must not be kept
    run_frame(1'b0, 16'h4C21, 12'h555, 16'h0000, 3, 0, 1'b1);
    idle(80, "R12 no conversion from dropped request");

    // R11: completion never arrives
    start_i = 1'b1;
    readback_i = 1'b1;
    for (int i = 0; i < CH; i++) begin
      step(5'b10100, "R11 convert strobe");
      start_i = 1'b0;
    end
    for (int j = 0; j < MXC; j++) step(5'b00100, "R11 waiting");
    step(5'b00001, "R11 timeout flag");
    check("R11 result kept", {20'd0, result_o}, {20'd0, exp_res});
    check("R11 channel kept", {29'd0, channel_o}, {29'd0, exp_ch});
    idle(70, "R10 idle after timeout");
    // recovery with a readback frame carrying channel 2
    run_frame(1'b1, 16'h1357, 12'h6AA, 16'h0855, 20, 0, 1'b0);
    idle(5, "R1 quiet");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule